// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is the target side of an I2C bus in front of a byte-wide memory. It recognises start and stop conditions, answers its own 7-bit device address, and serves reads from an internal byte array. A read may return the byte at the current pointer, or the controller may first set the pointer with a dummy write of two address bytes and then issue a repeated start with the read bit set. After the first byte, the controller keeps a read going by acknowledging each byte. The block then returns the byte at the next address. The pointer wraps from the highest address back to zero.

Data bytes that follow the two address bytes of a write transfer are stored at the pointer without any programming delay. This gives the array known content. The pointer is `ADDR_W` bits wide, 15 by default. The stored array covers `2**MEM_AW` bytes and repeats across the address space. SCL and SDA arrive already synchronized to `clk`. SDA leaves the block as an open-drain pull-down enable.

Top module: `i2c_seqread_eeprom`

## Requirements
- R1: SDA falling while SCL is high starts a new transfer that expects a device address byte. SDA rising while SCL is high ends any transfer, releases SDA and returns the block to standby. A stop after only one address byte leaves the pointer unchanged.
- R2: A device address byte whose upper seven bits differ from `DEV_ADDR` is not acknowledged. The block then stays released until the next start. With the default, 0xA0 selects write and 0xA1 selects read.
- R3: A random read works as follows. The controller writes the device address, then an upper address byte (its low `ADDR_W-8` bits become pointer bits `ADDR_W-1:8`), then a lower address byte (pointer bits 7:0). It then sends a repeated start and the read address. The first returned byte is the one at the loaded address.
- R4: A read that is not preceded by an address load returns the byte at the pointer as left by the previous transfer.
- R5: Data bytes are sent most significant bit first. SDA changes only while SCL is low.
- R6: When the controller acknowledges a returned byte, the next byte comes from the next consecutive address. The pointer advances after every byte sent.
- R7: After address 2**ADDR_W-1 (0x7FFF by default), the pointer wraps to 0 and the stream continues from address 0.
- R8: If SDA is not low at the ninth clock of a returned byte, the block goes to standby and drives nothing on later clocks.
- R9: After reset, every byte of the array reads 0xFF, the pointer is 0 and SDA is released.
- R10: In a write transfer, each data byte after the two address bytes is stored at the pointer, and the pointer then advances with the same wrap. An address A and A+2**MEM_AW select the same stored byte.
- R11: The block pulls SDA low during the ninth clock of every byte it accepts: a matching device address, an address byte or a write data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level (wired bus) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The array is first read straight after reset, to show the all-ones content and the pointer at zero. It is then filled with an arithmetic byte pattern, so that every address returns a different value. A random read followed by a current read tells a loaded pointer apart from one carried over from the previous transfer. Reads that cross 0x7FFF, and a read at an address one array size higher, separate pointer wrap from storage aliasing. A not-acknowledged byte followed by extra clocks, a foreign device address, and a stop after a single address byte each show the line released and the pointer left alone.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } rd_state_e;

   typedef enum logic [1:0] {
      PH_DEV,
      PH_AHI,
      PH_ALO,
      PH_DATA
   } rx_phase_e;

   function automatic rx_phase_e next_phase(rx_phase_e p);
      case (p)
         PH_DEV:  return PH_AHI;
         PH_AHI:  return PH_ALO;
         default: return PH_DATA;
      endcase
   endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store #(
   parameter int MEM_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [MEM_AW-1:0] idx,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (we) begin
         cells[idx] <= wdata;
      end
   end

   assign rdata = cells[idx];

endmodule

// File: rtl/i2c_seqread_eeprom.sv
module i2c_seqread_eeprom
   import i2c_rd_pkg::*;
#(
   parameter int         ADDR_W   = 15,
   parameter int         MEM_AW   = 8,
   parameter logic [6:0] DEV_ADDR = 7'h50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W must lie in 9..16");
      end
      if (MEM_AW < 1 || MEM_AW > ADDR_W || MEM_AW > 12) begin : g_bad_mw
         $error("MEM_AW must lie in 1..min(ADDR_W,12)");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;
   rd_state_e         st;
   rx_phase_e         ph;
   logic [3:0]        bitcnt;
   logic [7:0]        rx_sh;
   logic [7:0]        tx_sh;
   logic [HI_W-1:0]   addr_hi;
   logic [ADDR_W-1:0] ptr;
   logic              rd_go;
   logic              mack;
   logic              byte_done, mem_we, tx_done, ptr_inc;
   logic [MEM_AW-1:0] mem_idx;
   logic [7:0]        mem_rdata;

   i2c_line_mon u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   generate
      if (MEM_AW == ADDR_W) begin : g_full
         assign mem_idx = ptr;
      end else begin : g_mirror
         assign mem_idx = ptr[MEM_AW-1:0];
      end
   endgenerate

   eeprom_byte_store #(.MEM_AW(MEM_AW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .idx   (mem_idx),
      .wdata (rx_sh),
      .rdata (mem_rdata)
   );

   assign byte_done = (st == ST_RX) && scl_fall && (bitcnt == 4'd8) && !start_det && !stop_det;
   assign mem_we    = byte_done && (ph == PH_DATA);
   assign tx_done   = (st == ST_TX) && scl_fall && (bitcnt == 4'd7) && !start_det && !stop_det;
   assign ptr_inc   = mem_we || tx_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_DEV;
         bitcnt  <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         addr_hi <= '0;
         ptr     <= '0;
         rd_go   <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (start_det) begin
         st     <= ST_RX;
         ph     <= PH_DEV;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         if (ptr_inc) ptr <= ptr + 1'b1;
         case (st)
            ST_RX: begin
               if (scl_rise) begin
                  rx_sh  <= {rx_sh[6:0], sda_i};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_done) begin
                  case (ph)
                     PH_DEV: begin
                        if (rx_sh[7:1] == DEV_ADDR) begin
                           rd_go  <= rx_sh[0];
                           sda_oe <= 1'b1;
                           st     <= ST_RX_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end
                     PH_AHI: begin
                        addr_hi <= rx_sh[HI_W-1:0];
                        rd_go   <= 1'b0;
                        sda_oe  <= 1'b1;
                        st      <= ST_RX_ACK;
                     end
                     PH_ALO: begin
                        ptr    <= {addr_hi, rx_sh};
                        rd_go  <= 1'b0;
                        sda_oe <= 1'b1;
                        st     <= ST_RX_ACK;
                     end
                     default: begin
                        rd_go  <= 1'b0;
                        sda_oe <= 1'b1;
                        st     <= ST_RX_ACK;
                     end
                  endcase
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rd_go) begin
                     st     <= ST_TX;
                     tx_sh  <= mem_rdata;
                     sda_oe <= ~mem_rdata[7];
                  end else begin
                     st     <= ST_RX;
                     ph     <= next_phase(ph);
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_TX: begin
               if (tx_done) begin
                  st     <= ST_TX_ACK;
                  sda_oe <= 1'b0;
               end else if (scl_fall) begin
                  tx_sh  <= {tx_sh[6:0], 1'b0};
                  sda_oe <= ~tx_sh[6];
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  mack <= ~sda_i;
               end else if (scl_fall) begin
                  if (mack) begin
                     st     <= ST_TX;
                     tx_sh  <= mem_rdata;
                     sda_oe <= ~mem_rdata[7];
                     bitcnt <= '0;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/i2c_seqread_eeprom_chk.sv
module i2c_seqread_eeprom_chk
   import i2c_rd_pkg::*;
#(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input rd_state_e         st,
   input logic              scl_fall,
   input logic              start_det,
   input logic              stop_det,
   input logic              mack,
   input logic [ADDR_W-1:0] ptr,
   input logic              ptr_inc
);

   p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_i))
      else $error("R5: SDA drive changed while SCL high");

   p_ptr_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_inc && (&ptr) && !start_det && !stop_det) |=> (ptr == '0))
      else $error("R7: pointer did not wrap to zero");

   p_nack_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX_ACK && scl_fall && !mack && !start_det && !stop_det)
      |=> (st == ST_IDLE && !sda_oe))
      else $error("R8: missing acknowledge did not end the read");

   p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> (st == ST_IDLE && !sda_oe))
      else $error("R1: stop did not release the line");

endmodule

bind i2c_seqread_eeprom i2c_seqread_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_oe    (sda_oe),
   .st        (st),
   .scl_fall  (scl_fall),
   .start_det (start_det),
   .stop_det  (stop_det),
   .mack      (mack),
   .ptr       (ptr),
   .ptr_inc   (ptr_inc)
);

// File: tb/test_i2c_seqread_eeprom.sv
module test_i2c_seqread_eeprom;

   localparam int Q = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;

   int checks = 0;
   int errors = 0;
   logic [7:0] mdl [256];

   always #5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_seqread_eeprom i_i2c_seqread_eeprom (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_m),
      .sda_i  (sda_bus),
      .sda_oe (sda_oe)
   );

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack_line);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack_line = sda_bus;
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b[i] = sda_bus;
         scl_m = 1'b0;
      end
      tick(Q);
      sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic set_ptr(input logic [15:0] a);
      logic ak;
      bus_start();
      send_byte(8'hA0, ak);      chk("R11 dev ack", {8'h0, ak}, 9'h0);
      send_byte(a[15:8], ak);    chk("R11 hi ack", {8'h0, ak}, 9'h0);
      send_byte(a[7:0], ak);     chk("R11 lo ack", {8'h0, ak}, 9'h0);
   endtask

   task automatic write_run(input logic [15:0] a, input int n, input int seed);
      logic ak;
      logic [7:0] d;
      logic [14:0] p;
      set_ptr(a);
      p = a[14:0];
      for (int i = 0; i < n; i++) begin
         d = 8'((i + seed) * 37 + 5);
         send_byte(d, ak);
         chk("R10/R11 data ack", {8'h0, ak}, 9'h0);
         mdl[p[7:0]] = d;
         p = p + 1'b1;
      end
      bus_stop();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic ak;
      logic [7:0] b;
      logic [14:0] p;
      for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
      tick(4);
      chk("R9 released in reset", {8'h0, sda_oe}, 9'h0);
      rst_n = 1'b1;
      tick(4);
      chk("R9 released after reset", {8'h0, sda_oe}, 9'h0);

      // R9 / R4: current read straight after reset, pointer 0, content FF
      bus_start();
      send_byte(8'hA1, ak);       chk("R2 read addr ack", {8'h0, ak}, 9'h0);
      recv_byte(1'b0, b);         chk("R9 reset content", {1'b0, b}, 9'h0FF);
      bus_stop();

      // R10: fill 0x0010..0x0021 with pattern
      write_run(16'h0010, 18, 0);

      // R3 / R6 / R5: random read of 16 bytes
      set_ptr(16'h0010);
      bus_start();
      send_byte(8'hA1, ak);       chk("R3 read addr ack", {8'h0, ak}, 9'h0);
      for (int i = 0; i < 16; i++) begin
         recv_byte(i != 15, b);
         if (i == 0) chk("R3/R5 first byte", {1'b0, b}, {1'b0, mdl[8'h10]});
         else        chk("R6/R5 next byte", {1'b0, b}, {1'b0, mdl[8'(8'h10 + i)]});
      end
      bus_stop();

      // R4: current read continues at 0x0020
      bus_start();
      send_byte(8'hA1, ak);
      recv_byte(1'b0, b);         chk("R4 current read", {1'b0, b}, {1'b0, mdl[8'h20]});
      bus_stop();

      // R7: write across top of address space then read it back
      write_run(16'h7FFE, 3, 50);
      set_ptr(16'h7FFE);
      bus_start();
      send_byte(8'hA1, ak);
      p = 15'h7FFE;
      for (int i = 0; i < 3; i++) begin
         recv_byte(i != 2, b);
         chk(i == 2 ? "R7 wrapped byte" : "R6 byte below top", {1'b0, b}, {1'b0, mdl[p[7:0]]});
         p = p + 1'b1;
      end
      bus_stop();

      // R10: aliasing of stored bytes
      set_ptr(16'h01FE);
      bus_start();
      send_byte(8'hA1, ak);
      recv_byte(1'b0, b);         chk("R10 alias read", {1'b0, b}, {1'b0, mdl[8'hFE]});
      bus_stop();

      // R8: missing acknowledge then more clocks, line must stay released
      bus_start();
      send_byte(8'hA1, ak);
      recv_byte(1'b0, b);         chk("R4 byte before nack", {1'b0, b}, {1'b0, mdl[8'hFF]});
      recv_byte(1'b0, b);         chk("R8 released after nack", {1'b0, b}, 9'h0FF);
      bus_stop();

      // R2: foreign device address
      bus_start();
      send_byte(8'hA2, ak);       chk("R2 foreign addr no ack", {8'h0, ak}, 9'h1);
      recv_byte(1'b0, b);         chk("R2 released after mismatch", {1'b0, b}, 9'h0FF);
      bus_stop();

      // R1: stop after one address byte leaves pointer at 0x0200 (alias 0x00)
      bus_start();
      send_byte(8'hA0, ak);       chk("R1 dev ack", {8'h0, ak}, 9'h0);
      send_byte(8'h12, ak);
      bus_stop();
      bus_start();
      send_byte(8'hA1, ak);       chk("R1 restart ack", {8'h0, ak}, 9'h0);
      recv_byte(1'b0, b);         chk("R1 pointer kept", {1'b0, b}, {1'b0, mdl[8'h00]});
      bus_stop();
      chk("R1 released after stop", {8'h0, sda_oe}, 9'h0);

      tick(10);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule